// File: doc/BRIEF.md
# Event Latency Statistics Counter

This block watches one event that has a beginning and an end, each marked by a single-cycle pulse. It measures the time between the two pulses in clock cycles. For every completed occurrence it updates five statistics in the same clock cycle: an occurrence count, a running sum of latencies, a running sum of squared latencies, and the smallest and largest latency seen so far. It is meant to sit beside a pipeline or a bus agent. Software, or a debug path, reads the results later and derives the mean and variance from them.

Results come back through a small indexed read port as 32-bit words. Index 1 is the occurrence count. Indices 2 and 3 are the upper and lower words of the latency sum. Indices 4 and 5 are the upper and lower words of the squared sum. Index 6 is the minimum and index 7 is the maximum. The accumulator width `ACC_W` is 48 or 64, and it sets how the upper words are packed. Reading index 1 freezes a copy of the other statistics, so a full sweep from 1 to 7 returns one coherent set of values even while events keep completing.

Top module: `evlat_stats`

## Requirements
- R1: A measurement opens on `ev_start` and completes on the first `ev_stop` after it. The latency is the number of clock edges from the start edge to the stop edge. A start followed by a stop L cycles later measures L (L >= 1). An `ev_stop` with no open measurement is ignored and the count is unchanged.
- R2: Read index 1 returns the 32-bit number of completed measurements, taken from the live counter. The counter rises by one on each completion and holds at all ones.
- R3: Read index 3 returns bits 31:0 of the latency sum. Read index 2 returns the bits above 31.
- R4: Read index 5 returns bits 31:0 of the squared-latency sum. Read index 4 returns the bits above 31.
- R5: Read index 6 returns the smallest latency measured and index 7 returns the largest, zero-extended to 32 bits. The minimum is never above the maximum once the count is nonzero.
- R6: With `ACC_W`=48, indices 2 and 4 carry accumulator bits 47:32 in bits 15:0 and read zero in bits 31:16. With `ACC_W`=64, they carry bits 63:32.
- R7: When `clr` is high at a clock edge, the count and both sums become zero, the minimum becomes all ones, the maximum becomes zero, and any open measurement is dropped. The first measurement after a clear therefore sets both the minimum and the maximum.
- R8: Nothing wraps. The latency timer holds at 2^`LAT_W`-1, and the sums never decrease except on a clear.
- R9: A read of index 1 captures the sums, minimum and maximum. Reads of indices 2 to 7 return the captured values until the next read of index 1.
- R10: An `ev_start` while a measurement is open restarts the timer from that edge and does not add an occurrence.
- R11: `rd_data` is registered. It shows the item selected at the edge where `rd_en` was high, and it holds between reads. Index 0 returns zero.
- R12: After reset the count and sums are zero, the minimum is all ones, the maximum is zero, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| clr | input | 1 | Synchronous clear of all statistics |
| ev_start | input | 1 | Event start pulse |
| ev_stop | input | 1 | Event end pulse |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | 3 | Item index, 0 to 7 |
| rd_data | output | 32 | Registered item value |

## Verification
The hardest state to reach from the ports is saturation. With a 32-bit timer, no bench of reasonable length can fill a latency or a 48-bit sum. The bench therefore builds a second instance with a 4-bit timer and holds one event open for well over 15 cycles, so the clamp shows up directly in the minimum, maximum and sum items. To make a high word nonzero, one event runs for about 70,000 cycles, which pushes its square past 2^32. The snapshot rule is tested by letting an event complete between the read of index 1 and the reads that follow it, and then checking that those reads still return the older values.

// File: rtl/evlat_pkg.sv
package evlat_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 32;

  typedef enum logic [2:0] {
    ITEM_NONE   = 3'd0,
    ITEM_COUNT  = 3'd1,
    ITEM_SUM_HI = 3'd2,
    ITEM_SUM_LO = 3'd3,
    ITEM_SQ_HI  = 3'd4,
    ITEM_SQ_LO  = 3'd5,
    ITEM_MIN    = 3'd6,
    ITEM_MAX    = 3'd7
  } item_e;
endpackage

// File: rtl/evlat_timer.sv
module evlat_timer #(
  parameter int LAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ev_start,
  input  logic             ev_stop,
  output logic             meas_done,
  output logic             meas_open,
  output logic [LAT_W-1:0] meas_lat
);
  logic             open_q;
  logic [LAT_W-1:0] tmr_q;

  // completion needs an open window; clear wins over everything
  assign meas_done = open_q & ev_stop & ~clr;
  assign meas_open = open_q;
  assign meas_lat  = tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      tmr_q  <= '0;
    end else if (clr) begin
      open_q <= 1'b0;
      tmr_q  <= '0;
    end else if (ev_start) begin
      open_q <= 1'b1;
      tmr_q  <= LAT_W'(1);
    end else if (meas_done) begin
      open_q <= 1'b0;
      tmr_q  <= '0;
    end else if (open_q && (tmr_q != '1)) begin
      tmr_q  <= tmr_q + LAT_W'(1);
    end
  end
endmodule

// File: rtl/evlat_accum.sv
module evlat_accum #(
  parameter int W    = 48,
  parameter int IN_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            add_en,
  input  logic [IN_W-1:0] add_val,
  output logic [W-1:0]    acc
);
  localparam int SW = ((W > IN_W) ? W : IN_W) + 1;

  function automatic logic [W-1:0] sat_add(input logic [W-1:0] a,
                                           input logic [IN_W-1:0] b);
    logic [SW-1:0] s;
    s = SW'(a) + SW'(b);
    if (s > SW'({W{1'b1}})) return '1;
    return W'(s);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (clr)    acc <= '0;
    else if (add_en) acc <= sat_add(acc, add_val);
  end
endmodule

// File: rtl/evlat_extreme.sv
module evlat_extreme #(
  parameter int LAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd_en,
  input  logic [LAT_W-1:0] lat,
  output logic [LAT_W-1:0] lat_min,
  output logic [LAT_W-1:0] lat_max
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_min <= '1;
      lat_max <= '0;
    end else if (clr) begin
      lat_min <= '1;
      lat_max <= '0;
    end else if (upd_en) begin
      if (lat < lat_min) lat_min <= lat;
      if (lat > lat_max) lat_max <= lat;
    end
  end
endmodule

// File: rtl/evlat_readout.sv
module evlat_readout
  import evlat_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int LAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [2:0]        rd_idx,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ACC_W-1:0]  sum,
  input  logic [ACC_W-1:0]  sq,
  input  logic [LAT_W-1:0]  lat_min,
  input  logic [LAT_W-1:0]  lat_max,
  output logic              snap_take,
  output logic [DATA_W-1:0] rd_data
);
  // upper word: accumulator bits above 31, zero padded on the left
  function automatic logic [DATA_W-1:0] hi_word(input logic [ACC_W-1:0] v);
    return DATA_W'(64'(v) >> 32);
  endfunction

  function automatic logic [DATA_W-1:0] lo_word(input logic [ACC_W-1:0] v);
    return DATA_W'(v);
  endfunction

  item_e             sel;
  logic [ACC_W-1:0]  snap_sum, snap_sq;
  logic [LAT_W-1:0]  snap_min, snap_max;
  logic [DATA_W-1:0] nxt_word;

  assign sel       = item_e'(rd_idx);
  assign snap_take = rd_en && (sel == ITEM_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_sum <= '0;
      snap_sq  <= '0;
      snap_min <= '1;
      snap_max <= '0;
    end else if (snap_take) begin
      snap_sum <= sum;
      snap_sq  <= sq;
      snap_min <= lat_min;
      snap_max <= lat_max;
    end
  end

  always_comb begin
    case (sel)
      ITEM_COUNT:  nxt_word = DATA_W'(cnt);
      ITEM_SUM_HI: nxt_word = hi_word(snap_sum);
      ITEM_SUM_LO: nxt_word = lo_word(snap_sum);
      ITEM_SQ_HI:  nxt_word = hi_word(snap_sq);
      ITEM_SQ_LO:  nxt_word = lo_word(snap_sq);
      ITEM_MIN:    nxt_word = DATA_W'(snap_min);
      ITEM_MAX:    nxt_word = DATA_W'(snap_max);
      default:     nxt_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= nxt_word;
  end
endmodule

// File: rtl/evlat_stats.sv
module evlat_stats
  import evlat_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int LAT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        ev_start,
  input  logic        ev_stop,
  input  logic        rd_en,
  input  logic [2:0]  rd_idx,
  output logic [31:0] rd_data
);
  localparam int SQ_W = 2 * LAT_W;

  function automatic logic [SQ_W-1:0] lat_square(input logic [LAT_W-1:0] x);
    return SQ_W'(x) * SQ_W'(x);
  endfunction

  // named internal events, observed by the bound checker
  logic             meas_done;
  logic             meas_open;
  logic [LAT_W-1:0] meas_lat;
  logic [SQ_W-1:0]  meas_sq;
  logic             snap_take;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] sum_q, sq_q;
  logic [LAT_W-1:0] min_q, max_q;

  assign meas_sq = lat_square(meas_lat);

  evlat_timer #(.LAT_W(LAT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .meas_done(meas_done), .meas_open(meas_open), .meas_lat(meas_lat)
  );

  evlat_accum #(.W(CNT_W), .IN_W(1)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .add_en(meas_done), .add_val(1'b1), .acc(cnt_q)
  );

  evlat_accum #(.W(ACC_W), .IN_W(LAT_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .add_en(meas_done), .add_val(meas_lat), .acc(sum_q)
  );

  evlat_accum #(.W(ACC_W), .IN_W(SQ_W)) u_sq (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .add_en(meas_done), .add_val(meas_sq), .acc(sq_q)
  );

  evlat_extreme #(.LAT_W(LAT_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .upd_en(meas_done), .lat(meas_lat),
    .lat_min(min_q), .lat_max(max_q)
  );

  evlat_readout #(.ACC_W(ACC_W), .LAT_W(LAT_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .cnt(cnt_q), .sum(sum_q), .sq(sq_q),
    .lat_min(min_q), .lat_max(max_q),
    .snap_take(snap_take), .rd_data(rd_data)
  );
endmodule

// File: rtl/evlat_stats_chk.sv
module evlat_stats_chk #(
  parameter int ACC_W = 48,
  parameter int LAT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             ev_stop,
  input logic             rd_en,
  input logic [2:0]       rd_idx,
  input logic [31:0]      rd_data,
  input logic             meas_done,
  input logic [31:0]      cnt_q,
  input logic [ACC_W-1:0] sum_q,
  input logic [ACC_W-1:0] sq_q,
  input logic [LAT_W-1:0] min_q,
  input logic [LAT_W-1:0] max_q
);
  initial begin
    assert_width_ok_R6: assert ((ACC_W == 48 || ACC_W == 64) && LAT_W <= 32);
  end

  assert_no_phantom_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ev_stop) |=> $stable(cnt_q));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && meas_done && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 32'd1));

  assert_min_le_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (min_q <= max_q));

  assert_hi_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ACC_W == 48 && (rd_idx == 3'd2 || rd_idx == 3'd4))
      |=> (rd_data[31:16] == 16'h0));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && sum_q == '0 && sq_q == '0 &&
             min_q == '1 && max_q == '0));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (sum_q >= $past(sum_q) && sq_q >= $past(sq_q)));

  assert_idx0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == 3'd0) |=> (rd_data == 32'h0));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind evlat_stats evlat_stats_chk #(.ACC_W(ACC_W), .LAT_W(LAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ev_stop(ev_stop),
  .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
  .meas_done(meas_done), .cnt_q(cnt_q), .sum_q(sum_q), .sq_q(sq_q),
  .min_q(min_q), .max_q(max_q)
);

// File: tb/tb_evlat_stats.sv
module tb_evlat_stats;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, ev_start = 1'b0, ev_stop = 1'b0, rd_en = 1'b0;
  logic [2:0] rd_idx = 3'd0;
  logic [31:0] rd48, rd64, rds;
  logic s_start = 1'b0, s_stop = 1'b0, s_rd_en = 1'b0;
  logic [2:0] s_idx = 3'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evlat_stats #(.ACC_W(48)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ev_start(ev_start), .ev_stop(ev_stop),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd48));
  evlat_stats #(.ACC_W(64)) dut64 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ev_start(ev_start), .ev_stop(ev_stop),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd64));
  evlat_stats #(.ACC_W(48), .LAT_W(4)) dut_sat (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ev_start(s_start), .ev_stop(s_stop),
    .rd_en(s_rd_en), .rd_idx(s_idx), .rd_data(rds));

  int checks = 0, fails = 0;

  // reference model, restated from the requirements
  logic [63:0] m_cnt, m_sum, m_sq, s_sum, s_sq;
  logic [31:0] m_min, m_max, s_min, s_max;

  typedef struct { string req; int idx; logic [31:0] e48; logic [31:0] e64; } exp_t;
  exp_t q[$];
  logic pend = 1'b0;

  task automatic check(string req, string who, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, who, act, exp);
    end
  endtask

  function automatic logic [31:0] item(int idx, int w);
    case (idx)
      1: return m_cnt[31:0];
      2: return (w == 48) ? {16'h0, s_sum[47:32]} : s_sum[63:32];
      3: return s_sum[31:0];
      4: return (w == 48) ? {16'h0, s_sq[47:32]} : s_sq[63:32];
      5: return s_sq[31:0];
      6: return s_min;
      7: return s_max;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_clear();
    m_cnt = 0; m_sum = 0; m_sq = 0; m_min = 32'hFFFF_FFFF; m_max = 0;
  endtask

  // driver: issue a read and push what must come back
  task automatic read_item(int idx, string req);
    exp_t e;
    @(negedge clk);
    if (idx == 1) begin
      s_sum = m_sum; s_sq = m_sq; s_min = m_min; s_max = m_max;
    end
    e.req = req; e.idx = idx; e.e48 = item(idx, 48); e.e64 = item(idx, 64);
    q.push_back(e);
    rd_en = 1'b1; rd_idx = 3'(idx);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic read_all(string req);
    for (int i = 1; i <= 7; i++) read_item(i, req);
  endtask

  // monitor: compare one cycle after each accepted read (R11)
  always @(posedge clk) pend <= rd_en;
  always @(negedge clk) begin
    if (pend) begin
      exp_t e;
      if (q.size() == 0) begin
        check("R11", "unexpected read", 32'h1, 32'h0);
      end else begin
        e = q.pop_front();
        check(e.req, $sformatf("w48 idx%0d", e.idx), rd48, e.e48);
        check(e.req, $sformatf("w64 idx%0d", e.idx), rd64, e.e64);
      end
    end
  end

  // one measurement of L cycles (R1)
  task automatic measure(int lat);
    @(negedge clk); ev_start = 1'b1;
    @(negedge clk); ev_start = 1'b0;
    repeat (lat - 1) @(negedge clk);
    ev_stop = 1'b1;
    @(negedge clk); ev_stop = 1'b0;
    m_cnt = m_cnt + 1;
    m_sum = m_sum + 64'(lat);
    m_sq  = m_sq + 64'(lat) * 64'(lat);
    if (32'(lat) < m_min) m_min = 32'(lat);
    if (32'(lat) > m_max) m_max = 32'(lat);
  endtask

  task automatic sat_read(int idx, logic [31:0] exp, string req);
    @(negedge clk); s_rd_en = 1'b1; s_idx = 3'(idx);
    @(negedge clk); s_rd_en = 1'b0;
    check(req, $sformatf("sat idx%0d", idx), rds, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    s_sum = 0; s_sq = 0; s_min = 32'hFFFF_FFFF; s_max = 0;
    repeat (3) @(negedge clk);
    check("R12", "rd_data after reset", rd48, 32'h0);
    rst_n = 1'b1;
    read_all("R12");
    read_item(0, "R11");

    // basic measurements
    measure(5);
    read_item(1, "R1");
    measure(3);
    measure(10);
    read_item(1, "R2");
    read_item(2, "R6");
    read_item(3, "R3");
    read_item(4, "R6");
    read_item(5, "R4");
    read_item(6, "R5");
    read_item(7, "R5");

    // stop with nothing open is ignored (R1)
    @(negedge clk); ev_stop = 1'b1;
    @(negedge clk); ev_stop = 1'b0;
    read_item(1, "R1");

    // restart while open (R10): only the second start counts
    @(negedge clk); ev_start = 1'b1;
    @(negedge clk); ev_start = 1'b0;
    repeat (3) @(negedge clk);
    measure(6);
    read_item(1, "R10");
    read_item(3, "R10");
    read_item(7, "R10");

    // snapshot coherence (R9)
    read_item(1, "R9");
    measure(2);
    for (int i = 2; i <= 7; i++) read_item(i, "R9");
    read_item(1, "R9");
    read_item(6, "R9");

    // long event drives the square above 32 bits (R6, R4)
    measure(70000);
    read_item(1, "R2");
    read_item(4, "R6");
    read_item(5, "R4");
    read_item(2, "R3");
    read_item(3, "R3");

    // clear (R7), then first event sets both extremes
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    model_clear();
    read_all("R7");
    measure(4);
    read_all("R7");

    // saturation with a 4-bit timer (R8)
    @(negedge clk); s_start = 1'b1;
    @(negedge clk); s_start = 1'b0;
    repeat (30) @(negedge clk);
    s_stop = 1'b1;
    @(negedge clk); s_stop = 1'b0;
    sat_read(1, 32'd1, "R8");
    sat_read(7, 32'd15, "R8");
    sat_read(6, 32'd15, "R8");
    sat_read(3, 32'd15, "R8");
    sat_read(5, 32'd225, "R8");

    repeat (4) @(negedge clk);
    check("R11", "pending reads", 32'(q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule